// File: doc/BRIEF.md
# Registered Slice-Based Arithmetic/Logic Unit

This block is an 8-bit arithmetic and logic unit assembled from equal-width function slices chained by a carry network. Two operands, a carry input, a mode bit and a four-bit function code pick one of thirty-two functions: sixteen bitwise logic functions and sixteen arithmetic functions. The live result and a four-bit live flag word (zero, negative, carry/borrow, all-ones equality) come straight from the combinational datapath.

Two registers sit behind the datapath, each with its own write enable. One captures the live result and the other captures the live flags on a rising clock edge. The held flags are always driven. The held result is placed on a shared bus only while the output enable is high. Otherwise the output is released to high impedance so that other agents can drive the same bus.

The slice width, the slice count and the carry network style (slice-to-slice ripple or flat lookahead) are parameters. Every variant computes the same values.

Top module: `regalu8`

## Requirements
- R1: With logic_mode=1 the result for func_sel 0..15 is, in order: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A. cin has no effect.
- R2: With logic_mode=0 the result is the low byte of a sum plus cin. For func_sel 0..15 the sum is, in order: A, A|B, A|~B, 255, A+(A&~B), (A|B)+(A&~B), A+~B (A minus B minus 1), (A&~B)+255, A+(A&B), A+B, (A|~B)+(A&B), (A&B)+255, A+A, (A|B)+A, (A|~B)+A, A+255.
- R3: In arithmetic mode flag bit 2 (carry/borrow) is bit 8 of the R2 sum plus cin. For subtraction (func_sel 0110), cin=1 means no incoming borrow. The flag is low when a borrow occurred and high when none occurred.
- R4: In logic mode flag bit 2 is 0.
- R5: Flag bit 0 (zero) is high exactly when all result bits are 0.
- R6: Flag bit 1 (negative) equals the result's most significant bit.
- R7: Flag bit 3 (equality) is high when every slice's output is all ones. With logic_mode=0, func_sel=0110 and cin=0 it is therefore high exactly when A equals B.
- R8: On a rising edge with res_we high the live result is captured into the result register. With res_we low the register holds its value.
- R9: On a rising edge with flg_we high the live flag word is captured into the flag register, which is always driven on flg_held. With flg_we low it holds its value.
- R10: res_bus shows the result register while res_oe is high. While res_oe is low it is high impedance, so a bus pull-up reads all ones.
- R11: A synchronous active-high rst clears both registers on the next rising edge, taking priority over the write enables.
- R12: The ripple and lookahead carry network variants give identical live results and flags for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both registers |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| cin | input | 1 | Carry in (active-low borrow in for subtraction) |
| logic_mode | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| func_sel | input | 4 | Function code within the mode |
| res_we | input | 1 | Result register write enable |
| flg_we | input | 1 | Flag register write enable |
| res_oe | input | 1 | Drive the held result onto res_bus |
| res_live | output | 8 | Combinational result |
| res_bus | output | 8 | Held result, or high impedance |
| flg_live | output | 4 | Combinational flags {equality, carry/borrow, negative, zero} |
| flg_held | output | 4 | Held flags, same order |

## Verification
The bench builds the block at the default geometry of two 4-bit slices. The primary instance uses the lookahead carry network and a second instance uses slice-to-slice ripple, and both are compared against the same behavioural model. This geometry exercises the carry crossing from bit 3 into bit 4 and the equality flag that needs both slices to agree. Because the operands are only 8 bits wide, all 32 functions can be swept across random operands, carry inputs and enable patterns. A bench pull-up on the bus makes the released state observable as all ones.

// File: rtl/regalu8_pkg.sv
package regalu8_pkg;
   localparam int FLG_W     = 4;
   localparam int FLG_ZERO  = 0;
   localparam int FLG_NEG   = 1;
   localparam int FLG_CARRY = 2;
   localparam int FLG_EQ    = 3;
   localparam int SEL_W     = 4;

   typedef struct packed {
      logic eq;
      logic cy;
      logic neg;
      logic zero;
   } alu_flags_t;
endpackage

// File: rtl/alu_fn_slice.sv
module alu_fn_slice #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   sel,
   input  logic         logic_mode,
   input  logic         cin,
   output logic [W-1:0] f,
   output logic         grp_gen,
   output logic         grp_prop,
   output logic         all_ones
);
   localparam int SUM_W = W + 1;

   logic [W-1:0]     term_x;
   logic [W-1:0]     term_y;
   logic [SUM_W-1:0] raw_sum;
   logic [W-1:0]     arith_f;
   logic [W-1:0]     logic_f;

   if (W < 1) begin : g_bad_w
      $error("alu_fn_slice: W must be at least 1");
   end

   always_comb begin
      term_x = a | (b & {W{sel[0]}}) | (~b & {W{sel[1]}});
      term_y = (a & ~b & {W{sel[2]}}) | (a & b & {W{sel[3]}});
   end

   assign raw_sum  = {1'b0, term_x} + {1'b0, term_y};
   assign grp_gen  = raw_sum[W];
   assign grp_prop = &raw_sum[W-1:0];
   assign arith_f  = raw_sum[W-1:0] + {{(W-1){1'b0}}, cin};
   assign logic_f  = ~(term_x ^ term_y);
   assign f        = logic_mode ? logic_f : arith_f;
   assign all_ones = &f;
endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
   parameter int N         = 2,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic         cin,
   input  logic [N-1:0] gen,
   input  logic [N-1:0] prop,
   output logic [N:0]   carry
);
   if (N < 1) begin : g_bad_n
      $error("alu_carry_net: N must be at least 1");
   end

   if (LOOKAHEAD) begin : g_flat
      always_comb begin
         logic acc;
         logic term;
         carry[0] = cin;
         for (int j = 1; j <= N; j++) begin
            acc = 1'b0;
            for (int k = 0; k < j; k++) begin
               term = gen[k];
               for (int m = k + 1; m < j; m++) term = term & prop[m];
               acc = acc | term;
            end
            term = cin;
            for (int m = 0; m < j; m++) term = term & prop[m];
            carry[j] = acc | term;
         end
      end
   end else begin : g_ripple
      assign carry[0] = cin;
      for (genvar i = 0; i < N; i++) begin : g_stage
         assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
      end
   end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
   import regalu8_pkg::*;
#(
   parameter int W = 8,
   parameter int N = 2
) (
   input  logic [W-1:0]     f,
   input  logic [N-1:0]     slice_ones,
   input  logic             carry_out,
   input  logic             logic_mode,
   output logic [FLG_W-1:0] flags
);
   alu_flags_t fl;

   always_comb begin
      fl.zero = ~(|f);
      fl.neg  = f[W-1];
      fl.cy   = logic_mode ? 1'b0 : carry_out;
      fl.eq   = &slice_ones;
   end

   assign flags = fl;
endmodule

// File: rtl/alu_store.sv
module alu_store #(
   parameter int W  = 8,
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          res_we,
   input  logic          flg_we,
   input  logic          res_oe,
   input  logic [W-1:0]  res_in,
   input  logic [FW-1:0] flg_in,
   output logic [W-1:0]  res_q,
   output logic [FW-1:0] flg_q,
   output logic [W-1:0]  res_bus
);
   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         flg_q <= '0;
      end else begin
         if (res_we) res_q <= res_in;
         if (flg_we) flg_q <= flg_in;
      end
   end

   assign res_bus = res_oe ? res_q : {W{1'bz}};
endmodule

// File: rtl/regalu8.sv
module regalu8
   import regalu8_pkg::*;
#(
   parameter int  SLICE_W    = 4,
   parameter int  NUM_SLICES = 2,
   parameter bit  LOOKAHEAD  = 1'b1,
   localparam int DATA_W     = SLICE_W * NUM_SLICES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              cin,
   input  logic              logic_mode,
   input  logic [SEL_W-1:0]  func_sel,
   input  logic              res_we,
   input  logic              flg_we,
   input  logic              res_oe,
   output logic [DATA_W-1:0] res_live,
   output logic [DATA_W-1:0] res_bus,
   output logic [FLG_W-1:0]  flg_live,
   output logic [FLG_W-1:0]  flg_held
);
   logic [NUM_SLICES:0]   carry;
   logic [NUM_SLICES-1:0] grp_gen;
   logic [NUM_SLICES-1:0] grp_prop;
   logic [NUM_SLICES-1:0] slice_ones;
   logic [DATA_W-1:0]     fn_out;
   logic [DATA_W-1:0]     res_held;

   if (SLICE_W < 1 || NUM_SLICES < 1) begin : g_bad_geom
      $error("regalu8: slice width and count must be positive");
   end

   for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
      alu_fn_slice #(.W(SLICE_W)) u_slice (
         .a          (opnd_a[i*SLICE_W +: SLICE_W]),
         .b          (opnd_b[i*SLICE_W +: SLICE_W]),
         .sel        (func_sel),
         .logic_mode (logic_mode),
         .cin        (carry[i]),
         .f          (fn_out[i*SLICE_W +: SLICE_W]),
         .grp_gen    (grp_gen[i]),
         .grp_prop   (grp_prop[i]),
         .all_ones   (slice_ones[i])
      );
   end

   alu_carry_net #(.N(NUM_SLICES), .LOOKAHEAD(LOOKAHEAD)) u_carry (
      .cin   (cin),
      .gen   (grp_gen),
      .prop  (grp_prop),
      .carry (carry)
   );

   alu_flag_gen #(.W(DATA_W), .N(NUM_SLICES)) u_flags (
      .f          (fn_out),
      .slice_ones (slice_ones),
      .carry_out  (carry[NUM_SLICES]),
      .logic_mode (logic_mode),
      .flags      (flg_live)
   );

   assign res_live = fn_out;

   alu_store #(.W(DATA_W), .FW(FLG_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .res_we  (res_we),
      .flg_we  (flg_we),
      .res_oe  (res_oe),
      .res_in  (fn_out),
      .flg_in  (flg_live),
      .res_q   (res_held),
      .flg_q   (flg_held),
      .res_bus (res_bus)
   );
endmodule

// File: rtl/regalu8_chk.sv
module regalu8_chk
   import regalu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              logic_mode,
   input logic              res_we,
   input logic              flg_we,
   input logic [DATA_W-1:0] res_live,
   input logic [FLG_W-1:0]  flg_live,
   input logic [FLG_W-1:0]  flg_held,
   input logic [DATA_W-1:0] res_held
);
   assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
      flg_live[FLG_ZERO] == (res_live == '0));

   assert_neg_flag_R6: assert property (@(posedge clk) disable iff (rst)
      flg_live[FLG_NEG] == res_live[DATA_W-1]);

   assert_logic_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
      logic_mode |-> !flg_live[FLG_CARRY]);

   assert_eq_implies_ones_R7: assert property (@(posedge clk) disable iff (rst)
      flg_live[FLG_EQ] |-> (res_live == {DATA_W{1'b1}}));

   assert_res_capture_R8: assert property (@(posedge clk) disable iff (rst)
      res_we |=> (res_held == $past(res_live)));

   assert_res_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !res_we |=> $stable(res_held));

   assert_flg_capture_R9: assert property (@(posedge clk) disable iff (rst)
      flg_we |=> (flg_held == $past(flg_live)));

   assert_flg_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !flg_we |=> $stable(flg_held));

   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (res_held == '0 && flg_held == '0));
endmodule

bind regalu8 regalu8_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .logic_mode (logic_mode),
   .res_we     (res_we),
   .flg_we     (flg_we),
   .res_live   (res_live),
   .flg_live   (flg_live),
   .flg_held   (flg_held),
   .res_held   (res_held)
);

// File: tb/regalu8_tb.sv
`timescale 1ns/1ps
module regalu8_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] a, b;
   logic       c, lm, we_r, we_f, oe;
   logic [3:0] sel;
   wire  [7:0] bus_p, bus_r;
   logic [7:0] live_p, live_r;
   logic [3:0] fl_p, fl_r, held_p, held_r;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] m_res;
   logic [3:0] m_flg;

   always #2 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_pull
      pullup (bus_p[i]);
      pullup (bus_r[i]);
   end

   regalu8 u_dut (
      .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .cin(c), .logic_mode(lm),
      .func_sel(sel), .res_we(we_r), .flg_we(we_f), .res_oe(oe),
      .res_live(live_p), .res_bus(bus_p), .flg_live(fl_p), .flg_held(held_p));

   regalu8 #(.LOOKAHEAD(1'b0)) u_alt (
      .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .cin(c), .logic_mode(lm),
      .func_sel(sel), .res_we(we_r), .flg_we(we_f), .res_oe(oe),
      .res_live(live_r), .res_bus(bus_r), .flg_live(fl_r), .flg_held(held_r));

   function automatic logic [11:0] ref_eval(input logic [7:0] ia, ib,
                                            input logic ic, ilm, input logic [3:0] is);
      logic [7:0] nb, aob, aonb, anb, aab, r;
      logic cy;
      int s;
      nb = ~ib; aob = ia | ib; aonb = ia | nb; anb = ia & nb; aab = ia & ib;
      r = 8'h00; cy = 1'b0; s = 0;
      if (ilm) begin
         case (is)
            4'd0:  r = ~ia;         4'd1:  r = ~aob;
            4'd2:  r = ~ia & ib;    4'd3:  r = 8'h00;
            4'd4:  r = ~aab;        4'd5:  r = nb;
            4'd6:  r = ia ^ ib;     4'd7:  r = anb;
            4'd8:  r = ~ia | ib;    4'd9:  r = ~(ia ^ ib);
            4'd10: r = ib;          4'd11: r = aab;
            4'd12: r = 8'hFF;       4'd13: r = aonb;
            4'd14: r = aob;         default: r = ia;
         endcase
      end else begin
         case (is)
            4'd0:  s = int'(ia);                 4'd1:  s = int'(aob);
            4'd2:  s = int'(aonb);               4'd3:  s = 255;
            4'd4:  s = int'(ia) + int'(anb);     4'd5:  s = int'(aob) + int'(anb);
            4'd6:  s = int'(ia) + int'(nb);      4'd7:  s = int'(anb) + 255;
            4'd8:  s = int'(ia) + int'(aab);     4'd9:  s = int'(ia) + int'(ib);
            4'd10: s = int'(aonb) + int'(aab);   4'd11: s = int'(aab) + 255;
            4'd12: s = 2 * int'(ia);             4'd13: s = int'(aob) + int'(ia);
            4'd14: s = int'(aonb) + int'(ia);    default: s = int'(ia) + 255;
         endcase
         s  = s + int'(ic);
         r  = s[7:0];
         cy = s[8];
      end
      return {(r == 8'hFF), cy, r[7], (r == 8'h00), r};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] ia, ib, input logic ic, ilm, input logic [3:0] is,
                       input logic iwr, iwf, ioe, irst);
      logic [11:0] e;
      @(negedge clk);
      a = ia; b = ib; c = ic; lm = ilm; sel = is;
      we_r = iwr; we_f = iwf; oe = ioe; rst = irst;
      #1;
      e = ref_eval(ia, ib, ic, ilm, is);
      chk(ilm ? "R1 result" : "R2 result", 32'(live_p), 32'(e[7:0]));
      chk("R5 zero", 32'(fl_p[0]), 32'(e[8]));
      chk("R6 negative", 32'(fl_p[1]), 32'(e[9]));
      chk(ilm ? "R4 carry" : "R3 carry", 32'(fl_p[2]), 32'(e[10]));
      chk("R7 equality", 32'(fl_p[3]), 32'(e[11]));
      chk("R12 ripple variant", 32'({fl_r, live_r}), 32'({fl_p, live_p}));
      @(posedge clk);
      if (irst) begin
         m_res = 8'h00; m_flg = 4'h0;
      end else begin
         if (iwr) m_res = e[7:0];
         if (iwf) m_flg = e[11:8];
      end
      #1;
      chk(irst ? "R11 flags reset" : "R9 held flags", 32'(held_p), 32'(m_flg));
      chk(irst ? "R11 result reset" : (ioe ? "R8 held result" : "R10 released bus"),
          32'(bus_p), 32'(ioe ? m_res : 8'hFF));
      chk("R12 ripple variant held", 32'({held_r, bus_r}), 32'({held_p, bus_p}));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      a = 0; b = 0; c = 0; lm = 0; sel = 0; we_r = 0; we_f = 0; oe = 1; rst = 1;
      m_res = 0; m_flg = 0;
      // R11: reset with enables asserted still clears
      step(8'h12, 8'h34, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b1);
      step(8'h12, 8'h34, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b1);
      // R2/R6: 7F+01 -> 80 negative
      step(8'h7F, 8'h01, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0);
      // R3/R5: FF+01 -> 00 carry, zero
      step(8'hFF, 8'h01, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0);
      // R3: 05-03 with cin=1 -> 02 no borrow; 03-05 -> FE borrow
      step(8'h05, 8'h03, 1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0);
      step(8'h03, 8'h05, 1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0);
      // R7: A-B-1 with equal operands gives equality
      step(8'h5A, 8'h5A, 1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0);
      step(8'h5A, 8'h5B, 1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0);
      // carry across the slice boundary: 0F+01
      step(8'h0F, 8'h01, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0);
      // R1/R4: logic functions, cin ignored
      step(8'hF0, 8'h3C, 1'b1, 1'b1, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0);
      step(8'hF0, 8'h3C, 1'b1, 1'b1, 4'd11, 1'b1, 1'b1, 1'b1, 1'b0);
      step(8'hA5, 8'h00, 1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
      // R8/R9: enables low hold the previous capture
      step(8'h01, 8'h01, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0, 1'b1, 1'b0);
      step(8'hFF, 8'hFF, 1'b0, 1'b1, 4'd12, 1'b0, 1'b1, 1'b1, 1'b0);
      step(8'h21, 8'h00, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0, 1'b1, 1'b0);
      // R10: bus released while output enable is low
      step(8'h00, 8'h00, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      step(8'h00, 8'h00, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0);
      // R11: reset mid-run
      step(8'h44, 8'h11, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b1);
      // sweep: every function with random operands and controls
      for (int n = 0; n < 6000; n++) begin
         logic [31:0] rv;
         rv = $urandom;
         step(rv[7:0], rv[15:8], rv[16], rv[17], rv[21:18], rv[22], rv[23],
              rv[24] | rv[25], (rv[31:26] == 6'd0));
      end
      finish_run();
   end
endmodule